// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This unit serves the move-to and move-from special register instructions of a small 32-bit core. A 16-bit register address is split into a 5-bit group in the upper bits and an 11-bit index in the lower bits. A write strobe with 32-bit data updates the selected register. A read strobe loads a registered 32-bit result that is valid on the following cycle.

The bank holds the following registers:
- the exception vector base, the saved exception PC, the saved effective address and the saved status word;
- a 64-bit accumulator, reached as two 32-bit halves;
- a power-management word;
- an interrupt mask and pending-status pair;
- banked shadow copies of the general registers.

Identification words and the core index and count are constants set by parameters. Any address the unit does not implement returns the caller's incoming destination value unchanged, and writes to such an address are dropped. Writing a doze or sleep enable into the power word sends a one-cycle halt request to the pipeline, together with an indication that the PC should advance by 4.

Top module: `sreg_access_unit`

## Requirements
- R1: The address is decoded as group = addr[15:11] and index = addr[10:0].
- R2: Group 0 holds four read/write registers: index 11 is the vector base, 32 the exception PC, 48 the effective address and 64 the exception status. Each reads back the last value written to it.
- R3: Group 0 indices from 1024 up to 1024+NUM_BANKS*32-1 are the shadow registers. For offset = index-1024, the bank is offset/32 and the register within the bank is offset%32. An index above that range is unimplemented.
- R4: In group 5, index 1 is the low half of the 64-bit accumulator and index 2 is the high half. A write to one half leaves the other half unchanged.
- R5: Writing group 9 index 2 clears each interrupt status bit whose write-data bit is 1. Group 9 index 0 is a plain read/write mask. Both read back zero-extended to 32 bits.
- R6: Each irq_set[i] high for a cycle sets status bit i on the next edge. A set wins over a software clear of the same bit in the same cycle.
- R7: irq_req is high exactly when some status bit and the matching mask bit are both 1.
- R8: Group 8 index 0 is the power word. A write that has bit 4 (doze) or bit 5 (sleep) set makes halt_req and pc_adv4 high for the single cycle after that write. Any other write leaves both low.
- R9: A read of an unimplemented address returns rd_dest as sampled with the read strobe. This includes group 0 indices 5..8, groups 1..4, and group 9 index 1.
- R10: Group 0 indices 0..4, 9 and 10 return the identification parameters. Index 128 returns CORE_ID and index 129 returns MAX_CORES.
- R11: Writes to read-only or unimplemented addresses change no register.
- R12: rd_data loads on the edge that samples rd_en and holds otherwise. A read that coincides with a write to the same register returns the value held before the write. After reset, all registers, rd_data and the request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Register address (group, index) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_dest | input | 32 | Incoming destination value, returned for unmapped reads |
| rd_data | output | 32 | Registered read result |
| irq_set | input | IRQ_W | Per-bit interrupt set pulses |
| irq_req | output | 1 | Masked interrupt request |
| halt_req | output | 1 | One-cycle halt request after a power-mode write |
| pc_adv4 | output | 1 | PC-advance-by-4 indication that accompanies halt_req |

## Verification
- **Read results:** read data is due one edge after the read strobe. Each read is driven on a falling edge, and the result is sampled on the next falling edge.
- **Writes:** register state is updated on the edge that samples the write strobe. Every write is therefore checked by a read issued later.
- **Halt and PC-advance:** both outputs are sampled on the falling edge right after a power write, then again one cycle later to confirm they fell.
- **Interrupt status and request:** status takes an interrupt set pulse on the sampling edge. irq_req is combinational from status, so it is checked on the falling edge that follows.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int GRP_LSB   = 11;
  localparam int BANK_REGS = 32;
  localparam int PM_DOZE   = 4;
  localparam int PM_SLEEP  = 5;

  typedef enum logic [3:0] {
    K_NONE, K_ROM, K_VBASE, K_EPC, K_EADDR, K_ESTAT,
    K_SHADOW, K_ACC_LO, K_ACC_HI, K_POWER, K_IMASK, K_ISTAT
  } sreg_kind_e;

  function automatic logic [ADDR_W-1:0] sreg_addr(input logic [4:0] grp,
                                                  input logic [10:0] idx);
    return {grp, idx};
  endfunction

  function automatic logic pm_halt_hit(input logic [DATA_W-1:0] d);
    return d[PM_DOZE] | d[PM_SLEEP];
  endfunction
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int          NUM_BANKS  = 2,
  parameter int          SH_IDX_W   = 6,
  parameter logic [31:0] ID_VER     = 32'h1200_0001,
  parameter logic [31:0] ID_UNITS   = 32'h0000_0615,
  parameter logic [31:0] ID_CPUCFG  = 32'h0000_0020,
  parameter logic [31:0] ID_DXLCFG  = 32'h0000_0018,
  parameter logic [31:0] ID_IXLCFG  = 32'h0000_0019,
  parameter logic [31:0] ID_VER2    = 32'h0100_0003,
  parameter logic [31:0] ID_ARCHVER = 32'h0101_0000,
  parameter int          CORE_ID    = 0,
  parameter int          MAX_CORES  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sreg_kind_e        kind,
  output logic [31:0]       rom_word,
  output logic [SH_IDX_W-1:0] sh_idx
);
  localparam int SH_ENT = NUM_BANKS * BANK_REGS;

  logic [4:0]  grp;
  logic [10:0] idx;
  logic [10:0] sh_off;

  assign grp    = addr[ADDR_W-1:GRP_LSB];
  assign idx    = addr[GRP_LSB-1:0];
  assign sh_off = idx - 11'd1024;
  assign sh_idx = sh_off[SH_IDX_W-1:0];

  always_comb begin
    kind     = K_NONE;
    rom_word = '0;
    case (grp)
      5'd0: begin
        case (idx)
          11'd0:   begin kind = K_ROM; rom_word = ID_VER;     end
          11'd1:   begin kind = K_ROM; rom_word = ID_UNITS;   end
          11'd2:   begin kind = K_ROM; rom_word = ID_CPUCFG;  end
          11'd3:   begin kind = K_ROM; rom_word = ID_DXLCFG;  end
          11'd4:   begin kind = K_ROM; rom_word = ID_IXLCFG;  end
          11'd9:   begin kind = K_ROM; rom_word = ID_VER2;    end
          11'd10:  begin kind = K_ROM; rom_word = ID_ARCHVER; end
          11'd11:  kind = K_VBASE;
          11'd32:  kind = K_EPC;
          11'd48:  kind = K_EADDR;
          11'd64:  kind = K_ESTAT;
          11'd128: begin kind = K_ROM; rom_word = 32'(CORE_ID);   end
          11'd129: begin kind = K_ROM; rom_word = 32'(MAX_CORES); end
          default: if (idx >= 11'd1024 && sh_off < 11'(SH_ENT)) kind = K_SHADOW;
        endcase
      end
      5'd5: begin
        if (idx == 11'd1) kind = K_ACC_LO;
        if (idx == 11'd2) kind = K_ACC_HI;
      end
      5'd8: if (idx == 11'd0) kind = K_POWER;
      5'd9: begin
        if (idx == 11'd0) kind = K_IMASK;
        if (idx == 11'd2) kind = K_ISTAT;
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/sreg_shadow_bank.sv
module sreg_shadow_bank #(
  parameter int NUM_ENT = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] ent [NUM_ENT];

  for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ent[gi] <= '0;
      else if (we && idx == IDX_W'(gi))       ent[gi] <= wdata;
    end
  end

  assign rdata = ent[idx];
endmodule

// File: rtl/sreg_irq_ctrl.sv
module sreg_irq_ctrl #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] wdata,
  input  logic [IRQ_W-1:0] set_in,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] stat,
  output logic             req
);
  function automatic logic [IRQ_W-1:0] stat_next(input logic [IRQ_W-1:0] cur,
                                                 input logic [IRQ_W-1:0] clr,
                                                 input logic [IRQ_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [IRQ_W-1:0] clr_vec;
  assign clr_vec = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      stat <= '0;
    end else begin
      if (mask_we) mask <= wdata;
      stat <= stat_next(stat, clr_vec, set_in);
    end
  end

  assign req = |(stat & mask);
endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
  import sreg_pkg::*;
#(
  parameter int          NUM_BANKS  = 2,
  parameter int          IRQ_W      = 8,
  parameter logic [31:0] ID_VER     = 32'h1200_0001,
  parameter logic [31:0] ID_UNITS   = 32'h0000_0615,
  parameter logic [31:0] ID_CPUCFG  = 32'h0000_0020,
  parameter logic [31:0] ID_DXLCFG  = 32'h0000_0018,
  parameter logic [31:0] ID_IXLCFG  = 32'h0000_0019,
  parameter logic [31:0] ID_VER2    = 32'h0100_0003,
  parameter logic [31:0] ID_ARCHVER = 32'h0101_0000,
  parameter int          CORE_ID    = 3,
  parameter int          MAX_CORES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      addr,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [31:0]      rd_dest,
  output logic [31:0]      rd_data,
  input  logic [IRQ_W-1:0] irq_set,
  output logic             irq_req,
  output logic             halt_req,
  output logic             pc_adv4
);
  localparam int SH_ENT   = NUM_BANKS * BANK_REGS;
  localparam int SH_IDX_W = $clog2(SH_ENT);

  sreg_kind_e          kind;
  logic [31:0]         rom_word;
  logic [SH_IDX_W-1:0] sh_idx;
  logic [31:0]         sh_rdata;
  logic [IRQ_W-1:0]    irq_mask, irq_stat;
  logic                dec_none;
  logic                pm_halt_ev;

  logic [31:0] vbase_q, epc_q, eaddr_q, estat_q, power_q;
  logic [63:0] acc_q;
  logic [31:0] rd_mux;

  sreg_decode #(
    .NUM_BANKS(NUM_BANKS), .SH_IDX_W(SH_IDX_W),
    .ID_VER(ID_VER), .ID_UNITS(ID_UNITS), .ID_CPUCFG(ID_CPUCFG),
    .ID_DXLCFG(ID_DXLCFG), .ID_IXLCFG(ID_IXLCFG), .ID_VER2(ID_VER2),
    .ID_ARCHVER(ID_ARCHVER), .CORE_ID(CORE_ID), .MAX_CORES(MAX_CORES)
  ) u_dec (
    .addr(addr), .kind(kind), .rom_word(rom_word), .sh_idx(sh_idx)
  );

  sreg_shadow_bank #(.NUM_ENT(SH_ENT), .IDX_W(SH_IDX_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(wr_en && kind == K_SHADOW),
    .idx(sh_idx), .wdata(wr_data), .rdata(sh_rdata)
  );

  sreg_irq_ctrl #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_en && kind == K_IMASK),
    .clr_we(wr_en && kind == K_ISTAT),
    .wdata(wr_data[IRQ_W-1:0]), .set_in(irq_set),
    .mask(irq_mask), .stat(irq_stat), .req(irq_req)
  );

  assign dec_none   = (kind == K_NONE);
  assign pm_halt_ev = wr_en && kind == K_POWER && pm_halt_hit(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbase_q <= '0; epc_q <= '0; eaddr_q <= '0; estat_q <= '0;
      power_q <= '0; acc_q <= '0;
    end else if (wr_en) begin
      case (kind)
        K_VBASE:  vbase_q      <= wr_data;
        K_EPC:    epc_q        <= wr_data;
        K_EADDR:  eaddr_q      <= wr_data;
        K_ESTAT:  estat_q      <= wr_data;
        K_POWER:  power_q      <= wr_data;
        K_ACC_LO: acc_q[31:0]  <= wr_data;
        K_ACC_HI: acc_q[63:32] <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      pc_adv4  <= 1'b0;
    end else begin
      halt_req <= pm_halt_ev;
      pc_adv4  <= pm_halt_ev;
    end
  end

  always_comb begin
    case (kind)
      K_ROM:    rd_mux = rom_word;
      K_VBASE:  rd_mux = vbase_q;
      K_EPC:    rd_mux = epc_q;
      K_EADDR:  rd_mux = eaddr_q;
      K_ESTAT:  rd_mux = estat_q;
      K_SHADOW: rd_mux = sh_rdata;
      K_ACC_LO: rd_mux = acc_q[31:0];
      K_ACC_HI: rd_mux = acc_q[63:32];
      K_POWER:  rd_mux = power_q;
      K_IMASK:  rd_mux = 32'(irq_mask);
      K_ISTAT:  rd_mux = 32'(irq_stat);
      default:  rd_mux = rd_dest;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/sreg_access_unit_chk.sv
module sreg_access_unit_chk
  import sreg_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      addr,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             rd_en,
  input logic [31:0]      rd_dest,
  input logic [31:0]      rd_data,
  input logic [IRQ_W-1:0] irq_set,
  input logic             halt_req,
  input logic             pc_adv4,
  input logic             dec_none,
  input logic [IRQ_W-1:0] irq_stat,
  input logic [63:0]      acc_q
);
  logic pm_wr_hit, stat_wr, acc_hi_wr, acc_lo_wr;
  assign pm_wr_hit = wr_en && addr == sreg_addr(5'd8, 11'd0) && (wr_data[5:4] != 2'b00);
  assign stat_wr   = wr_en && addr == sreg_addr(5'd9, 11'd2);
  assign acc_lo_wr = wr_en && addr == sreg_addr(5'd5, 11'd1);
  assign acc_hi_wr = wr_en && addr == sreg_addr(5'd5, 11'd2);

  p_halt_on_pm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pm_wr_hit |=> (halt_req && pc_adv4));
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_wr_hit |=> (!halt_req && !pc_adv4));
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_pass_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dec_none) |=> rd_data == $past(rd_dest));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((irq_stat & $past(irq_set)) == $past(irq_set)));
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && irq_set == '0) |=> irq_stat == ($past(irq_stat) & ~$past(wr_data[IRQ_W-1:0])));
  p_acc_lo_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hi_wr && !acc_lo_wr) |=> $stable(acc_q[31:0]));
  p_acc_hi_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lo_wr && !acc_hi_wr) |=> $stable(acc_q[63:32]));
endmodule

bind sreg_access_unit sreg_access_unit_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_dest(rd_dest), .rd_data(rd_data), .irq_set(irq_set),
  .halt_req(halt_req), .pc_adv4(pc_adv4), .dec_none(dec_none),
  .irq_stat(irq_stat), .acc_q(acc_q)
);

// File: tb/sreg_access_unit_test.sv
`timescale 1ns/1ps
module sreg_access_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_dest = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_set = '0;
  logic        irq_req, halt_req, pc_adv4;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sreg_access_unit uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_dest(rd_dest), .rd_data(rd_data), .irq_set(irq_set),
    .irq_req(irq_req), .halt_req(halt_req), .pc_adv4(pc_adv4)
  );

  function automatic logic [15:0] ad(input int grp, input int idx);
    return 16'((grp << 11) + idx);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] dest, output logic [31:0] r);
    @(negedge clk); addr = a; rd_dest = dest; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; r = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] idw [7];
    int          idi [7];
    idw = '{32'h1200_0001, 32'h0000_0615, 32'h0000_0020, 32'h0000_0018,
            32'h0000_0019, 32'h0100_0003, 32'h0101_0000};
    idi = '{0, 1, 2, 3, 4, 9, 10};

    repeat (3) @(negedge clk);
    chk("R12 reset rd_data", rd_data, 32'h0);
    chk("R12 reset irq_req", 32'(irq_req), 32'h0);
    chk("R12 reset halt_req", 32'(halt_req), 32'h0);
    rst_n = 1'b1;
    rd(ad(0, 32), 32'hFFFF_FFFF, r); chk("R12 reset epc", r, 32'h0);

    // R1 R2: exception registers, addresses built as group<<11 + index
    begin
      int eidx [4];
      eidx = '{11, 32, 48, 64};
      for (int i = 0; i < 4; i++) wr(ad(0, eidx[i]), 32'hC0DE_0000 + 32'(i * 17));
      for (int i = 0; i < 4; i++) begin
        rd(ad(0, eidx[i]), 32'h0, r);
        chk("R2 R1 exception reg", r, 32'hC0DE_0000 + 32'(i * 17));
      end
    end

    // R3: shadow sweep over both banks
    for (int i = 0; i < 64; i++) wr(ad(0, 1024 + i), 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203));
    for (int b = 0; b < 2; b++)
      for (int g = 0; g < 32; g++) begin
        rd(ad(0, 1024 + b * 32 + g), 32'h0, r);
        chk("R3 shadow bank/reg", r, 32'h5A00_0000 ^ (32'(b * 32 + g) * 32'h0001_0203));
      end
    rd(ad(0, 1024 + 64), 32'h7777_1111, r); chk("R3 beyond shadow range", r, 32'h7777_1111);

    // R4: accumulator halves
    wr(ad(5, 1), 32'h1111_2222);
    wr(ad(5, 2), 32'h3333_4444);
    rd(ad(5, 1), 32'h0, r); chk("R4 acc lo", r, 32'h1111_2222);
    rd(ad(5, 2), 32'h0, r); chk("R4 acc hi", r, 32'h3333_4444);
    wr(ad(5, 1), 32'hAAAA_5555);
    rd(ad(5, 2), 32'h0, r); chk("R4 hi kept", r, 32'h3333_4444);
    rd(ad(5, 1), 32'h0, r); chk("R4 lo new", r, 32'hAAAA_5555);

    // R10 R11: identification words and core parameters, writes ignored
    for (int i = 0; i < 7; i++) begin
      wr(ad(0, idi[i]), 32'hFFFF_FFFF);
      rd(ad(0, idi[i]), 32'h0, r); chk("R10 R11 id word", r, idw[i]);
    end
    wr(ad(0, 128), 32'h0); rd(ad(0, 128), 32'h0, r); chk("R10 core id", r, 32'd3);
    wr(ad(0, 129), 32'h0); rd(ad(0, 129), 32'h0, r); chk("R10 max cores", r, 32'd4);
    wr(ad(1, 800), 32'h1234_5678);
    rd(ad(1, 800), 32'h0BAD_F00D, r); chk("R11 reserved write dropped", r, 32'h0BAD_F00D);
    wr(ad(5, 3), 32'hFFFF_FFFF);
    rd(ad(5, 1), 32'h0, r); chk("R11 acc lo untouched", r, 32'hAAAA_5555);
    rd(ad(5, 2), 32'h0, r); chk("R11 acc hi untouched", r, 32'h3333_4444);

    // R9: unimplemented address sweep
    begin
      int ug [9], ui [9];
      ug = '{0, 0, 0, 0, 3, 4, 1, 9, 31};
      ui = '{5, 6, 7, 8, 0, 2, 512, 1, 2047};
      for (int i = 0; i < 9; i++) begin
        rd(ad(ug[i], ui[i]), 32'hDEAD_0000 ^ 32'(ad(ug[i], ui[i])), r);
        chk("R9 pass-through", r, 32'hDEAD_0000 ^ 32'(ad(ug[i], ui[i])));
      end
    end

    // R5 R6 R7: interrupt mask, status, request
    wr(ad(9, 0), 32'h0000_000F);
    rd(ad(9, 0), 32'h0, r); chk("R5 mask readback", r, 32'h0000_000F);
    @(negedge clk); irq_set = 8'hF3;
    @(negedge clk); irq_set = 8'h00;
    chk("R7 irq_req on", 32'(irq_req), 32'h1);
    rd(ad(9, 2), 32'h0, r); chk("R6 status set", r, 32'h0000_00F3);
    wr(ad(9, 2), 32'h0000_0003);
    chk("R7 irq_req off", 32'(irq_req), 32'h0);
    rd(ad(9, 2), 32'h0, r); chk("R5 w1c", r, 32'h0000_00F0);
    @(negedge clk); addr = ad(9, 2); wr_data = 32'h30; wr_en = 1'b1; irq_set = 8'h10;
    @(negedge clk); wr_en = 1'b0; irq_set = 8'h00;
    rd(ad(9, 2), 32'h0, r); chk("R6 set beats clear", r, 32'h0000_00D0);
    wr(ad(9, 0), 32'h0000_0080);
    chk("R7 irq_req via bit7", 32'(irq_req), 32'h1);

    // R8: power word and halt pulse
    wr(ad(8, 0), 32'h0000_0010);
    chk("R8 halt doze", 32'(halt_req), 32'h1);
    chk("R8 pc_adv4 doze", 32'(pc_adv4), 32'h1);
    @(negedge clk);
    chk("R8 halt one cycle", 32'(halt_req), 32'h0);
    wr(ad(8, 0), 32'h0000_0020);
    chk("R8 halt sleep", 32'(halt_req), 32'h1);
    wr(ad(8, 0), 32'h0000_0001);
    chk("R8 no halt", 32'(halt_req), 32'h0);
    chk("R8 no pc_adv4", 32'(pc_adv4), 32'h0);
    rd(ad(8, 0), 32'h0, r); chk("R8 power readback", r, 32'h0000_0001);

    // R12: hold without strobe, read-during-write sees old value
    rd(ad(0, 11), 32'h0, r);
    @(negedge clk); addr = ad(0, 32);
    @(negedge clk); chk("R12 hold", rd_data, 32'hC0DE_0000);
    @(negedge clk); addr = ad(0, 11); wr_data = 32'h9999_0000; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 read old on write", rd_data, 32'hC0DE_0000);
    rd(ad(0, 11), 32'h0, r); chk("R12 new value after", r, 32'h9999_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule